// File: doc/BRIEF.md
# Control-Flow Instruction Monitor

This block runs beside a packet-processing soft core and follows the address of every instruction the core executes, one address per valid strobe. A table loaded before use tells it, for each instruction address, which basic block the instruction belongs to and where that instruction is allowed to branch. A basic block is a run of consecutive instructions that ends with a jump. The monitor remembers the block of the previously accepted instruction. Each new step must be one of three things: a move inside the same block, a move into the block numbered one higher, or a branch to the block that holds the target recorded for the previous instruction.

Any other step, and any address outside the table, is a violation. On a violation the monitor pulses a drop-and-recover request for one cycle. It then discards everything still in flight and forgets its history. For a fixed number of cycles it ignores incoming addresses while the core is being restored, and it treats the next accepted address as a fresh entry point. The check runs as a fixed four-stage pipeline with one table read in the first stage and a second read, at the previous instruction's branch target, in the fourth.

Top module: `flow_guard`

## Requirements
- R1: Table entries (block number, branch target) are written through the load port only while `enable` is low; a write while `enable` is high leaves the table unchanged, and a write to an address at or beyond `TBL_DEPTH` is dropped.
- R2: The first address accepted after reset, after recovery or after the monitor is re-enabled is an entry point and is legal whatever its block number.
- R3: An address whose block number equals the block number of the previously accepted address is legal.
- R4: An address whose block number is one more than the previous block number, modulo 2^BLK_W, is legal (so the highest block followed by block 0 is legal).
- R5: Otherwise the step is legal only if the table entry at the previous instruction's branch target lies inside the table and holds the same block number as the current address.
- R6: An address that fails R2 to R5 raises `dropPulse` in the cycle after the fifth rising clock edge counted from the edge that samples the address.
- R7: An address at or beyond `TBL_DEPTH` is a violation, even when it would be an entry point.
- R8: `dropPulse` lasts exactly one cycle, and addresses accepted after the offending one and still in the pipeline are discarded without raising a further pulse.
- R9: For the `RECOV_CYC` rising edges after the edge that raises `dropPulse`, valid addresses are ignored; the edge after those accepts input again and that address is an entry point.
- R10: While `enable` is low, addresses are ignored and the previous-block history is cleared.
- R11: Cycles with `addrValid` low do not change the history; the next valid address is compared with the last accepted one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Monitoring enabled; low opens the table for loading |
| addrValid | input | 1 | An executed instruction address is present on `addrIn` |
| addrIn | input | ADDR_W | Address of the executed instruction |
| tblWe | input | 1 | Table write strobe |
| tblWrAddr | input | ADDR_W | Table entry to write |
| tblWrBlk | input | BLK_W | Basic-block number for that entry |
| tblWrHop | input | ADDR_W | Permitted branch target for that entry |
| dropPulse | output | 1 | One-cycle drop-and-recover request |

## Verification
The bench builds the monitor with an 8-bit address, a 64-entry table, 4-bit block numbers and a 3-cycle recovery window. The narrow address leaves a wide range of out-of-table addresses and branch targets to exercise. The 4-bit block field lets a run wrap from block 15 to block 0. The short recovery window makes it possible to probe the last ignored and the first accepted edge exactly. The table is filled so that legal branches, branches to unrelated blocks and a branch target outside the table can all be set up from short address sequences.

// File: rtl/flow_guard_pkg.sv
package flow_guard_pkg;

  // Strobes from the control unit to the datapath.
  typedef struct packed {
    logic accept;  // capture addrIn into stage 1 this edge
    logic flush;   // clear pipeline valids and history this edge
    logic memWe;   // write the load-port entry into the table
  } fg_strobe_t;

endpackage

// File: rtl/flow_guard_dp.sv
module flow_guard_dp
  import flow_guard_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int TBL_DEPTH = 512,
  parameter int BLK_W     = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              dropPulse,
  input  fg_strobe_t        strobe,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic [ADDR_W-1:0] tblWrAddr,
  input  logic [BLK_W-1:0]  tblWrBlk,
  input  logic [ADDR_W-1:0] tblWrHop,
  output logic              viol
);

  localparam int IDX_W = (TBL_DEPTH > 1) ? $clog2(TBL_DEPTH) : 1;
  localparam logic [ADDR_W:0] DEPTH_V = (ADDR_W+1)'(TBL_DEPTH);

  // Table storage
  logic [BLK_W-1:0]  memBlk [TBL_DEPTH];
  logic [ADDR_W-1:0] memHop [TBL_DEPTH];

  logic              wrInRange;
  logic [IDX_W-1:0]  wrIdx;

  assign wrInRange = {1'b0, tblWrAddr} < DEPTH_V;
  assign wrIdx     = wrInRange ? tblWrAddr[IDX_W-1:0] : '0;

  always_ff @(posedge clk) begin
    if (strobe.memWe && wrInRange) begin
      memBlk[wrIdx] <= tblWrBlk;
      memHop[wrIdx] <= tblWrHop;
    end
  end

  // Stage 1: captured address, table read launched
  logic              s1Vld;
  logic [ADDR_W-1:0] s1Addr;
  logic              s1Oor;
  logic [IDX_W-1:0]  s1Idx;

  always_ff @(posedge clk) begin
    if (!rst_n) s1Vld <= 1'b0;
    else        s1Vld <= strobe.accept;
  end

  always_ff @(posedge clk) begin
    if (strobe.accept) s1Addr <= addrIn;
  end

  assign s1Oor = {1'b0, s1Addr} >= DEPTH_V;
  assign s1Idx = s1Oor ? '0 : s1Addr[IDX_W-1:0];

  // Stage 2: block number and branch target forwarded
  logic              s2Vld;
  logic              s2Oor;
  logic [BLK_W-1:0]  s2Blk;
  logic [ADDR_W-1:0] s2Hop;

  always_ff @(posedge clk) begin
    if (!rst_n) s2Vld <= 1'b0;
    else        s2Vld <= s1Vld && !strobe.flush;
  end

  always_ff @(posedge clk) begin
    s2Oor <= s1Oor;
    s2Blk <= memBlk[s1Idx];
    s2Hop <= memHop[s1Idx];
  end

  // History of the last accepted instruction: reading yields the
  // previous entry while the same edge stores the current one.
  logic              lastHas;
  logic [BLK_W-1:0]  lastBlk;
  logic [ADDR_W-1:0] lastHop;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lastHas <= 1'b0;
      lastBlk <= '0;
      lastHop <= '0;
    end else if (strobe.flush) begin
      lastHas <= 1'b0;
    end else if (s2Vld) begin
      lastHas <= 1'b1;
      lastBlk <= s2Blk;
      lastHop <= s2Hop;
    end
  end

  // Stage 3: sequential-step decision
  logic              s3Vld;
  logic              s3Oor;
  logic              s3Entry;
  logic [BLK_W-1:0]  s3Blk;
  logic [BLK_W-1:0]  s3PrevBlk;
  logic [ADDR_W-1:0] s3PrevHop;

  always_ff @(posedge clk) begin
    if (!rst_n) s3Vld <= 1'b0;
    else        s3Vld <= s2Vld && !strobe.flush;
  end

  always_ff @(posedge clk) begin
    s3Oor     <= s2Oor;
    s3Blk     <= s2Blk;
    s3Entry   <= !lastHas;
    s3PrevBlk <= lastBlk;
    s3PrevHop <= lastHop;
  end

  logic             sameBlk;
  logic             nextBlk;
  logic             seqOk;
  logic             hopOor;
  logic [IDX_W-1:0] hopIdx;

  assign sameBlk = s3Blk == s3PrevBlk;
  assign nextBlk = s3Blk == BLK_W'(s3PrevBlk + 1'b1);
  assign seqOk   = s3Entry || sameBlk || nextBlk;
  assign hopOor  = {1'b0, s3PrevHop} >= DEPTH_V;
  assign hopIdx  = hopOor ? '0 : s3PrevHop[IDX_W-1:0];

  // Stage 4: branch-target lookup and final verdict
  logic             s4Vld;
  logic             s4Oor;
  logic             s4NeedJmp;
  logic             s4HopOor;
  logic [BLK_W-1:0] s4Blk;
  logic [BLK_W-1:0] s4JmpBlk;

  always_ff @(posedge clk) begin
    if (!rst_n) s4Vld <= 1'b0;
    else        s4Vld <= s3Vld && !strobe.flush;
  end

  always_ff @(posedge clk) begin
    s4Oor     <= s3Oor;
    s4NeedJmp <= !seqOk;
    s4HopOor  <= hopOor;
    s4Blk     <= s3Blk;
    s4JmpBlk  <= memBlk[hopIdx];
  end

  assign viol = s4Vld &&
                (s4Oor || (s4NeedJmp && (s4HopOor || (s4JmpBlk != s4Blk))));

  // Assertions
  a_r8_flush_young: assert property (@(posedge clk) disable iff (!rst_n)
    dropPulse |-> (!s1Vld && !s2Vld && !s3Vld && !s4Vld));

  a_r6_from_stage4: assert property (@(posedge clk) disable iff (!rst_n)
    dropPulse |-> $past(s4Vld));

  a_r9_history_gone: assert property (@(posedge clk) disable iff (!rst_n)
    dropPulse |-> !lastHas);

  a_r10_off_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !s1Vld);

  a_r1_load_gated: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.memWe |-> !enable);

endmodule

// File: rtl/flow_guard_ctrl.sv
module flow_guard_ctrl
  import flow_guard_pkg::*;
#(
  parameter int RECOV_CYC = 6
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       enable,
  input  logic       addrValid,
  input  logic       tblWe,
  input  logic       viol,
  output fg_strobe_t strobe,
  output logic       dropPulse
);

  localparam int CNT_W = $clog2(RECOV_CYC + 1) > 0 ? $clog2(RECOV_CYC + 1) : 1;

  logic [CNT_W-1:0] recovCnt;
  logic             recovBusy;

  assign recovBusy = recovCnt != '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      recovCnt  <= '0;
      dropPulse <= 1'b0;
    end else begin
      dropPulse <= viol;
      if (viol)           recovCnt <= CNT_W'(RECOV_CYC);
      else if (recovBusy) recovCnt <= recovCnt - 1'b1;
    end
  end

  always_comb begin
    strobe.flush  = viol || !enable;
    strobe.accept = enable && addrValid && !recovBusy && !viol;
    strobe.memWe  = tblWe && !enable;
  end

  a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    dropPulse |=> !dropPulse);

  a_r9_window_opens: assert property (@(posedge clk) disable iff (!rst_n)
    dropPulse |-> recovBusy || (RECOV_CYC == 0));

endmodule

// File: rtl/flow_guard.sv
module flow_guard
  import flow_guard_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int TBL_DEPTH = 512,
  parameter int BLK_W     = 8,
  parameter int RECOV_CYC = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              addrValid,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic              tblWe,
  input  logic [ADDR_W-1:0] tblWrAddr,
  input  logic [BLK_W-1:0]  tblWrBlk,
  input  logic [ADDR_W-1:0] tblWrHop,
  output logic              dropPulse
);

  fg_strobe_t strobe;
  logic       viol;

  flow_guard_ctrl #(
    .RECOV_CYC(RECOV_CYC)
  ) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (enable),
    .addrValid (addrValid),
    .tblWe     (tblWe),
    .viol      (viol),
    .strobe    (strobe),
    .dropPulse (dropPulse)
  );

  flow_guard_dp #(
    .ADDR_W    (ADDR_W),
    .TBL_DEPTH (TBL_DEPTH),
    .BLK_W     (BLK_W)
  ) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (enable),
    .dropPulse (dropPulse),
    .strobe    (strobe),
    .addrIn    (addrIn),
    .tblWrAddr (tblWrAddr),
    .tblWrBlk  (tblWrBlk),
    .tblWrHop  (tblWrHop),
    .viol      (viol)
  );

endmodule

// File: tb/sim_flow_guard.sv
`timescale 1ns/1ps
module sim_flow_guard;

  localparam int AW    = 8;
  localparam int DEPTH = 64;
  localparam int BW    = 4;
  localparam int RC    = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          enable = 1'b0;
  logic          addrValid = 1'b0;
  logic [AW-1:0] addrIn = '0;
  logic          tblWe = 1'b0;
  logic [AW-1:0] tblWrAddr = '0;
  logic [BW-1:0] tblWrBlk = '0;
  logic [AW-1:0] tblWrHop = '0;
  logic          dropPulse;

  always #10 clk = ~clk;

  flow_guard #(
    .ADDR_W(AW), .TBL_DEPTH(DEPTH), .BLK_W(BW), .RECOV_CYC(RC)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .enable(enable), .addrValid(addrValid),
    .addrIn(addrIn), .tblWe(tblWe), .tblWrAddr(tblWrAddr),
    .tblWrBlk(tblWrBlk), .tblWrHop(tblWrHop), .dropPulse(dropPulse)
  );

  typedef struct {
    int    stamp;
    bit    exp;
    string tag;
  } item_t;

  item_t q[$];
  int cyc = 0;
  int nChecks = 0;
  int nFails = 0;
  bit finished = 0;

  // Reference model state
  int mBlk[DEPTH];
  int mHop[DEPTH];
  bit mHas = 0;
  bit mDead = 0;
  int mPrevBlk = 0;
  int mPrevHop = 0;

  always @(posedge clk) cyc <= cyc + 1;

  // Monitor: pop expected items as their sample cycle arrives
  always @(negedge clk) begin
    if (rst_n) begin
      if (q.size() > 0 && q[0].stamp == cyc) begin
        item_t it;
        it = q.pop_front();
        nChecks++;
        if (dropPulse !== it.exp) begin
          nFails++;
          $display("FAIL %s: dropPulse=%0d expected %0d (cycle %0d)",
                   it.tag, dropPulse, it.exp, cyc);
        end
      end else if (dropPulse !== 1'b0) begin
        nChecks++;
        nFails++;
        $display("FAIL R8: unexpected dropPulse=%0b expected 0 (cycle %0d)",
                 dropPulse, cyc);
      end
    end
  end

  function automatic int blkOf(int a);
    return (a >> 2) & 15;
  endfunction

  function automatic int hopOf(int a);
    return (a == 20) ? 200 : (a * 5 + 9) % 64;
  endfunction

  task automatic writeEntry(int a, int b, int h);
    tblWe = 1'b1; tblWrAddr = AW'(a); tblWrBlk = BW'(b); tblWrHop = AW'(h);
    if (!enable && a < DEPTH) begin
      mBlk[a] = b;
      mHop[a] = h;
    end
    @(negedge clk);
    tblWe = 1'b0;
  endtask

  // Driver: model the step, queue the expectation, present the address
  task automatic sendAddr(int a, string tag);
    bit v;
    v = 0;
    if (enable && !mDead) begin
      int b;
      b = (a < DEPTH) ? mBlk[a] : 0;
      if (a >= DEPTH)                                   v = 1;
      else if (!mHas)                                   v = 0;
      else if (b == mPrevBlk || b == (mPrevBlk + 1) % 16) v = 0;
      else if (mPrevHop >= DEPTH)                       v = 1;
      else                                              v = (mBlk[mPrevHop] != b);
      if (v) mDead = 1;
      else begin
        mHas = 1; mPrevBlk = b; mPrevHop = (a < DEPTH) ? mHop[a] : 0;
      end
    end
    q.push_back('{stamp: cyc + 5, exp: v, tag: tag});
    addrValid = 1'b1;
    addrIn = AW'(a);
    @(negedge clk);
    addrValid = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic recoverWait();
    idle(RC + 8);
    mDead = 0; mHas = 0;
  endtask

  task automatic restart();
    idle(6);
    enable = 1'b0;
    mHas = 0;
    @(negedge clk);
    enable = 1'b1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    nChecks++;
    if (dropPulse !== 1'b0) begin
      nFails++;
      $display("FAIL R8: reset dropPulse=%0b expected 0", dropPulse);
    end

    // R1: load the table while disabled
    for (int a = 0; a < DEPTH; a++) writeEntry(a, blkOf(a), hopOf(a));
    writeEntry(100, 3, 3);   // R1 out-of-range write is dropped
    enable = 1'b1;

    // R2 entry, R3 same block, R4 next block
    sendAddr(0, "R2"); sendAddr(1, "R3"); sendAddr(2, "R3");
    sendAddr(3, "R3"); sendAddr(4, "R4"); sendAddr(5, "R3");
    // R5 legal jumps: hop(5)=34 (blk 8), hop(33)=46 (blk 11)
    sendAddr(33, "R5"); sendAddr(44, "R5"); sendAddr(45, "R3");

    // R4 wrap 15 -> 0 via legal jump to block 15
    restart();
    sendAddr(22, "R2"); sendAddr(23, "R3"); sendAddr(60, "R5");
    sendAddr(61, "R3"); sendAddr(63, "R3"); sendAddr(0, "R4");
    sendAddr(1, "R3");
    // R6 illegal jump: hop(1)=14 (blk 3), 50 is blk 12
    sendAddr(50, "R6");
    recoverWait();

    // R7 out-of-range as entry and mid-stream
    sendAddr(100, "R7");
    recoverWait();
    sendAddr(8, "R2"); sendAddr(9, "R3"); sendAddr(70, "R7");
    recoverWait();

    // R8 one pulse, younger in-flight addresses discarded
    sendAddr(2, "R2"); sendAddr(3, "R3"); sendAddr(40, "R6");
    sendAddr(130, "R8"); sendAddr(131, "R8");
    recoverWait();

    // R5 branch target outside the table is not a legal jump
    sendAddr(20, "R2"); sendAddr(9, "R5");
    recoverWait();

    // R9 exact recovery window
    sendAddr(12, "R2"); sendAddr(41, "R6");   // hop(12)=5 blk1, 41 blk10
    idle(4);
    sendAddr(140, "R9");                      // first edge after the pulse
    idle(RC - 2);
    sendAddr(141, "R9");                      // last ignored edge
    mDead = 0; mHas = 0;
    sendAddr(50, "R9");                       // first accepted: entry
    sendAddr(13, "R9");                       // hop(50)=3 blk0, 13 blk3
    recoverWait();

    // R11 idle cycles keep history
    restart();
    sendAddr(4, "R2"); idle(3); sendAddr(5, "R11"); idle(2);
    sendAddr(6, "R11"); idle(4);
    sendAddr(57, "R11");                      // hop(6)=39 blk9, 57 blk14
    recoverWait();

    // R10 disabled: ignored and history cleared
    restart();
    sendAddr(12, "R2");
    idle(6);
    enable = 1'b0;
    sendAddr(100, "R10");
    enable = 1'b1;
    mHas = 0;
    sendAddr(50, "R10");                      // entry, would fail from blk 3
    sendAddr(51, "R3");

    // R1 write while enabled has no effect
    restart();
    writeEntry(40, 8, 0);
    sendAddr(30, "R2"); sendAddr(40, "R1");   // 30 blk7, 40 still blk10
    recoverWait();
    enable = 1'b0;
    writeEntry(40, 8, 0);
    enable = 1'b1;
    sendAddr(30, "R2"); sendAddr(40, "R1");   // now blk8: next block

    idle(10);
    if (q.size() != 0) begin
      nChecks++; nFails++;
      $display("FAIL R6: %0d expectations unresolved, expected 0", q.size());
    end
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
      $finish;
    end
  end

endmodule